// File: doc/BRIEF.md
# SDRAM Same-Bank Read/Write Pair Sequencer

This controller-side block takes one bank of an SDRAM through two back-to-back row cycles. The first cycle opens a row, reads a four-word burst and closes the row. The second cycle opens another row, writes a four-word burst and closes it. Each command goes out on active-low chip select, row strobe, column strobe and write enable, together with the bank and address lines. Clock enable stays high and the byte masks stay low.

A one-cycle `start_i` pulse in idle latches the bank, the read row and column, the write row and column, and the write burst. Each command is spaced by cycle-count parameters: activate-to-column delay, row-cycle time, precharge time, and write recovery counted from the last write word. The read CAS latency can be 2 or 3 and is chosen per run. The read burst is returned on `rd_data_o`. `done_o` pulses once the final precharge has been issued and the bank may be activated again.

Top module: `sdram_pair_seq`

## Requirements
- R1: While `rst_ni` is low, and during the first idle cycle after it is released, the command bus shows NOP ({cs,ras,cas,we} = 0111). `cke_o` is 1, `dqm_o` is 0, and `done_o` and `dq_oe_o` are 0. An asynchronous reset in the middle of a run returns the bus to NOP at once, and a later start runs normally.
- R2: A run issues exactly six non-NOP commands, in this order: activate (0011), read (0101), precharge (0010), activate, write (0100), precharge. Every other cycle is NOP.
- R3: Taking the first activate as cycle 0, the read issues at cycle T_RCD. The write issues T_RCD cycles after the second activate.
- R4: The read-side precharge issues BURST cycles after the read.
- R5: The second activate issues at max(Pr+T_RP, T_RC, Rd+CL+BURST+1, Pr+1), where Pr is the read precharge cycle and Rd is the read cycle. This keeps the row-cycle and precharge times, and makes sure the read burst has fully returned.
- R6: Read word k (k = 0..BURST-1) is sampled from `dq_i` at the clock edge that ends cycle Rd+CL+k, with CL = 3 when `cas3_i` was 1 at start and CL = 2 otherwise. It appears on `rd_data_o[k*DATA_W +: DATA_W]`.
- R7: `dq_oe_o` is 1 only in cycles W..W+BURST-1, where W is the write cycle. In cycle W+k, `dq_o` carries `wr_data_i[k*DATA_W +: DATA_W]` as latched at start.
- R8: The write-side precharge issues at W+BURST-1+T_RDL, which is T_RDL cycles after the last write word.
- R9: Activates carry the full row on `addr_o`, including bit 10. Column commands carry the column in the low bits with bit 10 = 0, so no auto-precharge is requested. Precharges drive bit 10 = 0, which selects only the addressed bank. `ba_o` carries the latched bank throughout.
- R10: `done_o` is high for exactly one cycle, at cycle max(P2+T_RP, A2+T_RC), where P2 is the write precharge cycle and A2 is the second activate cycle.
- R11: A `start_i` pulse, or a change to the address and bank inputs, while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run (accepted only when idle) |
| cas3_i | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| bank_i | input | BANK_W | Bank for both cycles |
| rd_row_i | input | ROW_W | Row opened for the read |
| rd_col_i | input | COL_W | Read column |
| wr_row_i | input | ROW_W | Row opened for the write |
| wr_col_i | input | COL_W | Write column |
| wr_data_i | input | BURST*DATA_W | Write burst, word 0 in the low bits |
| dq_i | input | DATA_W | Read data from the memory |
| done_o | output | 1 | One-cycle end-of-run pulse |
| rd_data_o | output | BURST*DATA_W | Captured read burst, word 0 in the low bits |
| cke_o | output | 1 | Clock enable, held high |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ROW_W | Row/column address, bit 10 = auto-precharge flag on column commands |
| dqm_o | output | DATA_W/8 | Byte masks, held low |
| dq_o | output | DATA_W | Write data |
| dq_oe_o | output | 1 | Write data drive enable |

## Verification
The bench builds the block with T_RC = 10, T_RCD = 3, T_RDL = 2, T_RP = 2 and a four-word burst of 16-bit words. With these values the gap before the second activate is set by the row-cycle time at CAS latency 2, and by the tail of the read burst at CAS latency 3. Both branches of R5 are therefore reached. At the end of a run the precharge time and the row-cycle time fall on the same cycle, so an off-by-one in either one moves `done_o`. The row values set address bit 10, so the bench can tell the row bit from the auto-precharge flag.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT_R,
    ST_RCD_R,
    ST_RD,
    ST_RBURST,
    ST_PRE_R,
    ST_GAP,
    ST_ACT_W,
    ST_RCD_W,
    ST_WR,
    ST_WBURST,
    ST_PRE_W,
    ST_TAIL,
    ST_DONE
  } state_e;

endpackage

// File: rtl/sdram_elapsed_cnt.sv
// Cycles since the last load; saturates at all ones (also the reset value).
module sdram_elapsed_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '1;
    else if (load_i)        cnt_o <= W'(1);
    else if (cnt_o != '1)   cnt_o <= cnt_o + W'(1);
  end

  a_r3_load_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == W'(1));

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int BURST  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  logic                    cas3_i,
  input  logic [DATA_W-1:0]       dq_i,
  output logic                    busy_o,
  output logic [BURST*DATA_W-1:0] data_o
);

  localparam int PW = $clog2(3 + BURST + 1) + 1;

  logic          active;
  logic [PW-1:0] ph;
  logic [PW-1:0] cl;
  logic [PW-1:0] idx;
  logic          cap;

  assign cl     = cas3_i ? PW'(3) : PW'(2);
  assign cap    = active && (ph >= cl) && (ph < cl + PW'(BURST));
  assign idx    = ph - cl;
  assign busy_o = active;

  // ph equals cycles elapsed since the read command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      ph     <= '0;
      data_o <= '0;
    end else begin
      if (go_i) begin
        active <= 1'b1;
        ph     <= PW'(1);
      end else if (active) begin
        ph <= ph + PW'(1);
        if (cap && idx == PW'(BURST - 1)) active <= 1'b0;
      end
      for (int k = 0; k < BURST; k++)
        if (cap && idx == PW'(k)) data_o[k*DATA_W +: DATA_W] <= dq_i;
    end
  end

  a_r6_ends_on_last_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(cap) && $past(idx) == PW'(BURST - 1)));

  a_r6_go_starts_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> busy_o);

endmodule

// File: rtl/sdram_pair_seq.sv
module sdram_pair_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int BURST  = 4,
  parameter int T_RC   = 7,
  parameter int T_RCD  = 2,
  parameter int T_RDL  = 2,
  parameter int T_RP   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    cas3_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [ROW_W-1:0]        rd_row_i,
  input  logic [COL_W-1:0]        rd_col_i,
  input  logic [ROW_W-1:0]        wr_row_i,
  input  logic [COL_W-1:0]        wr_col_i,
  input  logic [BURST*DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0]       dq_i,
  output logic                    done_o,
  output logic [BURST*DATA_W-1:0] rd_data_o,
  output logic                    cke_o,
  output logic                    cs_no,
  output logic                    ras_no,
  output logic                    cas_no,
  output logic                    we_no,
  output logic [BANK_W-1:0]       ba_o,
  output logic [ROW_W-1:0]        addr_o,
  output logic [DATA_W/8-1:0]     dqm_o,
  output logic [DATA_W-1:0]       dq_o,
  output logic                    dq_oe_o
);

  localparam int AP_BIT  = 10;
  localparam int WR_HOLD = BURST - 1 + T_RDL;
  localparam int MAX_A   = (T_RC > T_RCD) ? T_RC : T_RCD;
  localparam int MAX_B   = (WR_HOLD > T_RP) ? WR_HOLD : T_RP;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXT    = (MAX_C > BURST) ? MAX_C : BURST;
  localparam int CNT_W   = $clog2(MAXT + 2);

  localparam logic [CNT_W:0] P_ONE   = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] P_RC    = (CNT_W+1)'(T_RC);
  localparam logic [CNT_W:0] P_RCD   = (CNT_W+1)'(T_RCD);
  localparam logic [CNT_W:0] P_RP    = (CNT_W+1)'(T_RP);
  localparam logic [CNT_W:0] P_BURST = (CNT_W+1)'(BURST);
  localparam logic [CNT_W:0] P_HOLD  = (CNT_W+1)'(WR_HOLD);

  state_e state, state_nx;
  cmd_e   cmd;

  logic                    cas3_q;
  logic [BANK_W-1:0]       bank_q;
  logic [ROW_W-1:0]        rd_row_q, wr_row_q;
  logic [COL_W-1:0]        rd_col_q, wr_col_q;
  logic [BURST*DATA_W-1:0] wdata_q;

  logic [CNT_W-1:0] since_act, since_cmd;
  logic [CNT_W:0]   act_nx, cmd_nx;
  logic             rd_busy, rc_ok, ready_pre, ready_gap;

  sdram_elapsed_cnt #(.W(CNT_W)) i_act_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd == CMD_ACT),
    .cnt_o  (since_act)
  );

  sdram_elapsed_cnt #(.W(CNT_W)) i_cmd_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd != CMD_NOP),
    .cnt_o  (since_cmd)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .BURST(BURST)) i_rd_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (cmd == CMD_RD),
    .cas3_i (cas3_q),
    .dq_i   (dq_i),
    .busy_o (rd_busy),
    .data_o (rd_data_o)
  );

  // elapsed count as it will be in the next cycle
  assign act_nx    = {1'b0, since_act} + P_ONE;
  assign cmd_nx    = {1'b0, since_cmd} + P_ONE;
  assign rc_ok     = act_nx >= P_RC;
  assign ready_pre = (T_RP <= 1) && rc_ok && !rd_busy;
  assign ready_gap = (cmd_nx >= P_RP) && rc_ok && !rd_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cas3_q   <= 1'b0;
      bank_q   <= '0;
      rd_row_q <= '0;
      wr_row_q <= '0;
      rd_col_q <= '0;
      wr_col_q <= '0;
      wdata_q  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && start_i) begin
        cas3_q   <= cas3_i;
        bank_q   <= bank_i;
        rd_row_q <= rd_row_i;
        wr_row_q <= wr_row_i;
        rd_col_q <= rd_col_i;
        wr_col_q <= wr_col_i;
        wdata_q  <= wr_data_i;
      end
    end
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start_i) state_nx = ST_ACT_R;
      ST_ACT_R:  state_nx = (T_RCD <= 1) ? ST_RD : ST_RCD_R;
      ST_RCD_R:  if (act_nx >= P_RCD) state_nx = ST_RD;
      ST_RD:     state_nx = (BURST <= 1) ? ST_PRE_R : ST_RBURST;
      ST_RBURST: if (cmd_nx >= P_BURST) state_nx = ST_PRE_R;
      ST_PRE_R:  state_nx = ready_pre ? ST_ACT_W : ST_GAP;
      ST_GAP:    if (ready_gap) state_nx = ST_ACT_W;
      ST_ACT_W:  state_nx = (T_RCD <= 1) ? ST_WR : ST_RCD_W;
      ST_RCD_W:  if (act_nx >= P_RCD) state_nx = ST_WR;
      ST_WR:     state_nx = (WR_HOLD <= 1) ? ST_PRE_W : ST_WBURST;
      ST_WBURST: if (cmd_nx >= P_HOLD) state_nx = ST_PRE_W;
      ST_PRE_W:  state_nx = ready_pre ? ST_DONE : ST_TAIL;
      ST_TAIL:   if (ready_gap) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state)
      ST_ACT_R: begin cmd = CMD_ACT; addr_o = rd_row_q; end
      ST_ACT_W: begin cmd = CMD_ACT; addr_o = wr_row_q; end
      ST_RD: begin
        cmd                 = CMD_RD;
        addr_o[COL_W-1:0]   = rd_col_q;
        addr_o[AP_BIT]      = 1'b0;  // explicit precharge follows
      end
      ST_WR: begin
        cmd                 = CMD_WR;
        addr_o[COL_W-1:0]   = wr_col_q;
        addr_o[AP_BIT]      = 1'b0;
      end
      ST_PRE_R, ST_PRE_W: begin
        cmd            = CMD_PRE;
        addr_o[AP_BIT] = 1'b0;       // addressed bank only
      end
      default: ;
    endcase
  end

  always_comb begin
    dq_o = '0;
    for (int k = 0; k < BURST; k++)
      if ((state == ST_WR && k == 0) ||
          (state == ST_WBURST && since_cmd == CNT_W'(k)))
        dq_o = wdata_q[k*DATA_W +: DATA_W];
  end

  assign dq_oe_o = (state == ST_WR) ||
                   (state == ST_WBURST && {1'b0, since_cmd} < P_BURST);

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign cke_o  = 1'b1;
  assign dqm_o  = '0;
  assign ba_o   = bank_q;
  assign done_o = (state == ST_DONE);

  a_r3_col_after_rcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD || cmd == CMD_WR) |-> ({1'b0, since_act} >= P_RCD));

  a_r5_act_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> ({1'b0, since_act} >= P_RC));

  a_r5_no_act_while_reading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> !rd_busy);

  a_r8_wr_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE && state == ST_PRE_W) |-> ({1'b0, since_cmd} >= P_HOLD));

  a_r7_oe_opens_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (cmd == CMD_WR));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_hold_config: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> $stable(bank_q));

endmodule

// File: tb/test_sdram_pair_seq.sv
module test_sdram_pair_seq;

  localparam int ROW_W  = 13;
  localparam int COL_W  = 9;
  localparam int BANK_W = 2;
  localparam int DATA_W = 16;
  localparam int BURST  = 4;
  localparam int T_RC   = 10;
  localparam int T_RCD  = 3;
  localparam int T_RDL  = 2;
  localparam int T_RP   = 2;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  typedef struct packed {
    logic        cas3;
    logic [1:0]  bank;
    logic [12:0] rrow;
    logic [8:0]  rcol;
    logic [12:0] wrow;
    logic [8:0]  wcol;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 2'd0, 13'h0401, 9'h003, 13'h1abc, 9'h1f0, 16'h1234},
    '{1'b1, 2'd3, 13'h1fff, 9'h1ff, 13'h0000, 9'h000, 16'hA5A5},
    '{1'b1, 2'd1, 13'h0555, 9'h0aa, 13'h0aaa, 9'h155, 16'h0F0F},
    '{1'b0, 2'd2, 13'h07ff, 9'h100, 13'h1400, 9'h0ff, 16'hFFFF}
  };

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic                    cas3_i = 1'b0;
  logic [BANK_W-1:0]       bank_i = '0;
  logic [ROW_W-1:0]        rd_row_i = '0, wr_row_i = '0;
  logic [COL_W-1:0]        rd_col_i = '0, wr_col_i = '0;
  logic [BURST*DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0]       dq_i = '0;
  logic                    done_o, cke_o, cs_no, ras_no, cas_no, we_no, dq_oe_o;
  logic [BURST*DATA_W-1:0] rd_data_o;
  logic [BANK_W-1:0]       ba_o;
  logic [ROW_W-1:0]        addr_o;
  logic [DATA_W/8-1:0]     dqm_o;
  logic [DATA_W-1:0]       dq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  sdram_pair_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BURST(BURST),
    .T_RC(T_RC), .T_RCD(T_RCD), .T_RDL(T_RDL), .T_RP(T_RP)
  ) i_sdram_pair_seq (
    .clk_i, .rst_ni, .start_i, .cas3_i, .bank_i, .rd_row_i, .rd_col_i,
    .wr_row_i, .wr_col_i, .wr_data_i, .dq_i, .done_o, .rd_data_o, .cke_o,
    .cs_no, .ras_no, .cas_no, .we_no, .ba_o, .addr_o, .dqm_o, .dq_o, .dq_oe_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rword(vec_t v, int k);
    return v.seed ^ (16'h1111 * 16'(k));
  endfunction

  function automatic logic [15:0] wword(vec_t v, int k);
    return ~v.seed + 16'(3 * k + 1);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [3:0] bus_cmd();
    return {cs_no, ras_no, cas_no, we_no};
  endfunction

  task automatic check_idle(input string req);
    chk(bus_cmd() == C_NOP, req, 64'(bus_cmd()), 64'(C_NOP));
    chk(cke_o === 1'b1 && dqm_o === '0, req, {cke_o, dqm_o}, {1'b1, 2'b00});
    chk(done_o === 1'b0 && dq_oe_o === 1'b0, req, {done_o, dq_oe_o}, 0);
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int cl, er, ep, ea2, ew, ep2, ed;
    int n, rr, done_c, n_done, oe_err, dq_err, post_err;
    int cyc_at [6];
    logic [3:0]  typ [6];
    logic [12:0] adr [6];
    logic [1:0]  bas [6];
    logic [3:0]  cmd;
    bit exp_oe;
    cl  = v.cas3 ? 3 : 2;
    er  = T_RCD;
    ep  = er + BURST;
    ea2 = imax(imax(ep + T_RP, T_RC), imax(er + cl + BURST + 1, ep + 1));
    ew  = ea2 + T_RCD;
    ep2 = ew + BURST - 1 + T_RDL;
    ed  = imax(ep2 + T_RP, ea2 + T_RC);
    n = 0; rr = -1; done_c = -1; n_done = 0; oe_err = 0; dq_err = 0; post_err = 0;
    for (int i = 0; i < 6; i++) begin
      cyc_at[i] = -1; typ[i] = '0; adr[i] = '0; bas[i] = '0;
    end
    start_i  = 1'b1;
    cas3_i   = v.cas3;
    bank_i   = v.bank;
    rd_row_i = v.rrow;
    rd_col_i = v.rcol;
    wr_row_i = v.wrow;
    wr_col_i = v.wcol;
    for (int k = 0; k < BURST; k++) wr_data_i[k*DATA_W +: DATA_W] = wword(v, k);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (poke && c == 4) begin
        start_i = 1'b1; rd_row_i = ~v.rrow; wr_row_i = ~v.wrow;
        bank_i = ~v.bank; rd_col_i = ~v.rcol; wr_col_i = ~v.wcol; cas3_i = ~v.cas3;
      end
      if (poke && c == 5) start_i = 1'b0;
      cmd = bus_cmd();
      if (cmd != C_NOP) begin
        if (done_c >= 0) post_err++;
        if (n < 6) begin
          typ[n] = cmd; cyc_at[n] = c; adr[n] = addr_o; bas[n] = ba_o;
        end
        n++;
        if (cmd == C_RD && rr < 0) rr = c;
      end
      dq_i = 16'hBEEF;
      if (rr >= 0 && c >= rr + cl && c < rr + cl + BURST) dq_i = rword(v, c - rr - cl);
      exp_oe = (c >= ew) && (c < ew + BURST);
      if (dq_oe_o !== exp_oe) oe_err++;
      if (exp_oe && dq_o !== wword(v, c - ew)) dq_err++;
      if (done_o === 1'b1) begin
        n_done++;
        if (done_c < 0) done_c = c;
      end
      if (done_c >= 0 && c == done_c + 3) break;
      @(negedge clk_i);
    end
    // R2: order and encodings
    chk(n == 6 && post_err == 0, "R2 command count", 64'(n), 64'd6);
    chk(typ[0] == C_ACT, "R2 cmd0 activate", 64'(typ[0]), 64'(C_ACT));
    chk(typ[1] == C_RD,  "R2 cmd1 read",     64'(typ[1]), 64'(C_RD));
    chk(typ[2] == C_PRE, "R2 cmd2 precharge",64'(typ[2]), 64'(C_PRE));
    chk(typ[3] == C_ACT, "R2 cmd3 activate", 64'(typ[3]), 64'(C_ACT));
    chk(typ[4] == C_WR,  "R2 cmd4 write",    64'(typ[4]), 64'(C_WR));
    chk(typ[5] == C_PRE, "R2 cmd5 precharge",64'(typ[5]), 64'(C_PRE));
    chk(cyc_at[0] == 0,   "R3 first activate cycle", 64'(cyc_at[0]), 0);
    chk(cyc_at[1] == er,  "R3 read after tRCD",      64'(cyc_at[1]), 64'(er));
    chk(cyc_at[2] == ep,  "R4 read precharge cycle", 64'(cyc_at[2]), 64'(ep));
    chk(cyc_at[3] == ea2, "R5 second activate cycle",64'(cyc_at[3]), 64'(ea2));
    chk(cyc_at[4] == ew,  "R3 write after tRCD",     64'(cyc_at[4]), 64'(ew));
    chk(cyc_at[5] == ep2, "R8 write recovery",       64'(cyc_at[5]), 64'(ep2));
    // R9 / R11: addresses and bank come from the values latched at start
    chk(adr[0] == v.rrow, "R9 R11 read row", 64'(adr[0]), 64'(v.rrow));
    chk(adr[1] == {4'b0, v.rcol}, "R9 R11 read column A10=0", 64'(adr[1]), 64'({4'b0, v.rcol}));
    chk(adr[2][10] == 1'b0 && adr[5][10] == 1'b0, "R9 precharge A10=0", {adr[2][10], adr[5][10]}, 0);
    chk(adr[3] == v.wrow, "R9 R11 write row", 64'(adr[3]), 64'(v.wrow));
    chk(adr[4] == {4'b0, v.wcol}, "R9 R11 write column A10=0", 64'(adr[4]), 64'({4'b0, v.wcol}));
    chk(bas[0] == v.bank && bas[1] == v.bank && bas[2] == v.bank && bas[3] == v.bank &&
        bas[4] == v.bank && bas[5] == v.bank, "R9 R11 bank", 64'(bas[4]), 64'(v.bank));
    chk(rd_data_o == {rword(v, 3), rword(v, 2), rword(v, 1), rword(v, 0)}, "R6 read burst",
        rd_data_o, {rword(v, 3), rword(v, 2), rword(v, 1), rword(v, 0)});
    chk(oe_err == 0, "R7 dq_oe window", 64'(oe_err), 0);
    chk(dq_err == 0, "R7 write words", 64'(dq_err), 0);
    chk(done_c == ed, "R10 done cycle", 64'(done_c), 64'(ed));
    chk(n_done == 1, "R10 done width", 64'(n_done), 1);
    if (poke) chk(n_done == 1 && n == 6, "R11 start while busy ignored", 64'(n), 64'd6);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after release");

    for (int i = 0; i < 4; i++) run_vec(VECS[i], 1'b0);

    // R11: start pulse and new inputs mid-run
    run_vec(VECS[2], 1'b1);

    // R1: asynchronous reset in the middle of a run, then recovery
    start_i  = 1'b1;
    cas3_i   = 1'b1;
    bank_i   = 2'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_idle("R1 mid-run reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 idle after mid-run reset");
    run_vec(VECS[3], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule